// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller decides when the processor core stops and when it resumes. It watches the two wait strobes (wait-for-interrupt and wait-for-event) and a strobe that marks the return from the last pending interrupt handler. A small set of mode bits chooses between a light Sleep state and a Deepsleep state. For each state the controller drives the CPU clock gate, the core-domain clock gate, the two high-speed oscillator enables and the regulator mode.

The way a low-power state was entered fixes which inputs can end it. An entry by wait-for-interrupt is ended by any pending interrupt whose enable bit is set. An entry by wait-for-event is ended by one of two things: an external line whose event-mode bit is set, or a pending interrupt whose enable bit is clear while the send-on-pending bit is set. A wake from Deepsleep turns the oscillators on first. The core clocks stay gated until the oscillator-ready input is high. An event seen while running is remembered, so the next wait-for-event does not sleep. All pins are plain control and status levels or one-cycle pulses. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the state code `lp_state_o` is Run. Codes are Run=0, Sleep=1, Deepsleep=2, oscillator-wait=3. After reset both clock enables and both oscillator enables are 1, `reg_lowpwr_o` is 0 and both wake pulses are 0.
- R2: With `cfg_deep_i`=0 and `cfg_on_exit_i`=0, a `wfi_i` or `wfe_i` strobe in Run gives state Sleep after the next clock edge. The exception is a wait-for-event consumed under R11.
- R3: With `cfg_deep_i`=0 and `cfg_on_exit_i`=1, wait strobes in Run leave the state at Run, and a `handler_exit_i` strobe enters Sleep with wait-for-interrupt wake rules. With `cfg_on_exit_i`=0, `handler_exit_i` has no effect.
- R4: In Sleep, `cpu_clk_en_o`=0. `core_clk_en_o`, `osc_int_en_o` and `osc_ext_en_o` are all 1, and `reg_lowpwr_o`=0.
- R5: After entry by wait-for-interrupt, a bit set in both `irq_pend_i` and `irq_en_i` returns the state to Run on the next edge, with `wake_irq_o` high for exactly that first Run cycle. A pending bit whose enable is clear does not wake.
- R6: After entry by wait-for-event, either of two inputs gives Run on the next edge with `wake_fast_o` high for one cycle and `wake_irq_o` low: an `evt_line_i` bit whose `cfg_evt_mode_i` bit is 1, or (when `cfg_sev_pend_i`=1) a pending interrupt whose enable is 0. An event line whose mode bit is 0 does not wake.
- R7: With `cfg_deep_i`=1 and `cfg_lp_sel_i`=0, a wait strobe in Run enters Deepsleep whatever `cfg_on_exit_i` is. With `cfg_lp_sel_i`=1, the strobe leaves the state at Run.
- R8: In Deepsleep, both clock enables and both oscillator enables are 0. `reg_lowpwr_o` equals the value `cfg_reg_lp_i` had at entry, and later changes to that bit have no effect.
- R9: A wake source from Deepsleep (rules of R5/R6 by entry kind) gives the oscillator-wait state. There the oscillators are on, both clocks are gated and the regulator is normal. This state holds while `osc_ready_i`=0. The edge that sees `osc_ready_i`=1 returns to Run, with the wake pulse that matches the entry kind.
- R10: Wait strobes and `handler_exit_i` seen in Sleep, Deepsleep or oscillator-wait do not change the state.
- R11: A wait-for-event wake source seen in Run is latched. The next wait-for-event then leaves the state at Run, pulses `wake_fast_o` on the next cycle and clears the latch, so a following wait-for-event sleeps. A wait-for-interrupt does not clear the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_deep_i | input | 1 | Deep sleep select |
| cfg_on_exit_i | input | 1 | Sleep on return from last handler |
| cfg_lp_sel_i | input | 1 | Lowest-power select (strobe ignored when deep) |
| cfg_reg_lp_i | input | 1 | Regulator low-power request for Deepsleep |
| cfg_sev_pend_i | input | 1 | Pending unenabled interrupt counts as event |
| cfg_evt_mode_i | input | N_EVT | Per-line event-mode enable |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| handler_exit_i | input | 1 | Return from last handler strobe |
| irq_pend_i | input | N_IRQ | Peripheral interrupt pending lines |
| irq_en_i | input | N_IRQ | Interrupt controller enables |
| evt_line_i | input | N_EVT | External event lines |
| osc_ready_i | input | 1 | High-speed oscillators stable |
| lp_state_o | output | 2 | Current state code |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| core_clk_en_o | output | 1 | Core-domain clock enable |
| osc_int_en_o | output | 1 | Internal high-speed oscillator enable |
| osc_ext_en_o | output | 1 | External high-speed oscillator enable |
| reg_lowpwr_o | output | 1 | Regulator low-power mode |
| wake_fast_o | output | 1 | One-cycle pulse: event wake or consumed event |
| wake_irq_o | output | 1 | One-cycle pulse: interrupt wake |

## Verification
Most internal faults show up in `lp_state_o` and the gating outputs on the cycle after the edge that contains them. A wrong entry-kind bit shows up later. It reaches the ports only at wake time, as the wrong wake source being accepted or the wrong pulse firing. A stuck event latch shows up only at a later wait-for-event, which either stays in Run or sleeps when it should not. The scenario therefore separates the latching stimulus from its consuming strobe by idle cycles and sleep episodes. A wrongly captured regulator bit shows up while Deepsleep lasts, so the bench changes the bit in the middle of Deepsleep.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_DEEP  = 2'd2,
    PS_OSCW  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int N_IRQ = 4,
  parameter int N_EVT = 4
) (
  input  logic             sev_pend_i,
  input  logic [N_IRQ-1:0] irq_pend_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_EVT-1:0] evt_line_i,
  input  logic [N_EVT-1:0] evt_mode_i,
  output logic             irq_src_o,
  output logic             evt_src_o
);
  logic [N_IRQ-1:0] taken_vec;
  logic [N_IRQ-1:0] quiet_vec;
  logic [N_EVT-1:0] line_vec;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    assign taken_vec[i] = irq_pend_i[i] & irq_en_i[i];
    assign quiet_vec[i] = irq_pend_i[i] & ~irq_en_i[i];
  end
  for (genvar j = 0; j < N_EVT; j++) begin : g_evt
    assign line_vec[j] = evt_line_i[j] & evt_mode_i[j];
  end

  assign irq_src_o = |taken_vec;
  assign evt_src_o = (sev_pend_i & (|quiet_vec)) | (|line_vec);
endmodule

// File: rtl/pwr_event_latch.sv
module pwr_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic in_run_i,
  input  logic evt_src_i,
  input  logic consume_i,
  output logic latched_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      latched_o <= 1'b0;
    else if (consume_i)              latched_o <= 1'b0;
    else if (in_run_i && evt_src_i)  latched_o <= 1'b1;
  end

  a_r11_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run_i && evt_src_i && !consume_i) |=> latched_o);
  a_r11_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |=> !latched_o);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_deep_i,
  input  logic       cfg_on_exit_i,
  input  logic       cfg_lp_sel_i,
  input  logic       cfg_reg_lp_i,
  input  logic       wfi_i,
  input  logic       wfe_i,
  input  logic       handler_exit_i,
  input  logic       irq_src_i,
  input  logic       evt_src_i,
  input  logic       latched_i,
  input  logic       osc_ready_i,
  output pwr_state_e state_o,
  output logic       reg_lp_q_o,
  output logic       consume_o,
  output logic       wake_fast_o,
  output logic       wake_irq_o
);
  pwr_state_e st_q, st_d;
  logic kind_evt_q, kind_evt_d;
  logic reg_lp_d;
  logic fast_d, irq_d;
  logic strobe, evt_kind_req, evt_ready, wake_now;

  assign strobe       = wfi_i | wfe_i;
  assign evt_kind_req = wfe_i & ~wfi_i;
  assign evt_ready    = latched_i | evt_src_i;
  assign wake_now     = kind_evt_q ? evt_src_i : irq_src_i;

  always_comb begin
    st_d       = st_q;
    kind_evt_d = kind_evt_q;
    reg_lp_d   = reg_lp_q_o;
    fast_d     = 1'b0;
    irq_d      = 1'b0;
    consume_o  = 1'b0;
    unique case (st_q)
      PS_RUN: begin
        if (cfg_deep_i) begin
          if (strobe && !cfg_lp_sel_i) begin
            if (evt_kind_req && evt_ready) begin
              consume_o = 1'b1;
              fast_d    = 1'b1;
            end else begin
              st_d       = PS_DEEP;
              kind_evt_d = evt_kind_req;
              reg_lp_d   = cfg_reg_lp_i;
            end
          end
        end else if (!cfg_on_exit_i) begin
          if (strobe) begin
            if (evt_kind_req && evt_ready) begin
              consume_o = 1'b1;
              fast_d    = 1'b1;
            end else begin
              st_d       = PS_SLEEP;
              kind_evt_d = evt_kind_req;
            end
          end
        end else if (handler_exit_i) begin
          st_d       = PS_SLEEP;
          kind_evt_d = 1'b0;
        end
      end
      PS_SLEEP: begin
        if (wake_now) begin
          st_d   = PS_RUN;
          fast_d = kind_evt_q;
          irq_d  = ~kind_evt_q;
        end
      end
      PS_DEEP: begin
        if (wake_now) begin
          st_d     = PS_OSCW;
          reg_lp_d = 1'b0;
        end
      end
      PS_OSCW: begin
        if (osc_ready_i) begin
          st_d   = PS_RUN;
          fast_d = kind_evt_q;
          irq_d  = ~kind_evt_q;
        end
      end
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= PS_RUN;
      kind_evt_q  <= 1'b0;
      reg_lp_q_o  <= 1'b0;
      wake_fast_o <= 1'b0;
      wake_irq_o  <= 1'b0;
    end else begin
      st_q        <= st_d;
      kind_evt_q  <= kind_evt_d;
      reg_lp_q_o  <= reg_lp_d;
      wake_fast_o <= fast_d;
      wake_irq_o  <= irq_d;
    end
  end

  assign state_o = st_q;

  a_r5_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SLEEP && !kind_evt_q && irq_src_i) |=> (st_q == PS_RUN && wake_irq_o));
  a_r6_evt_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SLEEP && kind_evt_q && evt_src_i) |=> (st_q == PS_RUN && wake_fast_o && !wake_irq_o));
  a_r9_hold_oscw: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_OSCW && !osc_ready_i) |=> st_q == PS_OSCW);
  a_r8_reg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_DEEP && !wake_now) |=> $stable(reg_lp_q_o));
  a_r10_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SLEEP && !wake_now) |=> st_q == PS_SLEEP);
  a_r11_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_fast_o && wake_irq_o));
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state_i,
  input  logic       reg_lp_q_i,
  output logic       cpu_clk_en_o,
  output logic       core_clk_en_o,
  output logic       osc_int_en_o,
  output logic       osc_ext_en_o,
  output logic       reg_lowpwr_o
);
  always_comb begin
    cpu_clk_en_o  = 1'b0;
    core_clk_en_o = 1'b0;
    osc_int_en_o  = 1'b1;
    osc_ext_en_o  = 1'b1;
    reg_lowpwr_o  = 1'b0;
    unique case (state_i)
      PS_RUN: begin
        cpu_clk_en_o  = 1'b1;
        core_clk_en_o = 1'b1;
      end
      PS_SLEEP: core_clk_en_o = 1'b1;
      PS_DEEP: begin
        osc_int_en_o = 1'b0;
        osc_ext_en_o = 1'b0;
        reg_lowpwr_o = reg_lp_q_i;
      end
      PS_OSCW: ;
      default: ;
    endcase
  end

  a_r4_sleep_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == PS_SLEEP) |-> (!cpu_clk_en_o && core_clk_en_o && osc_int_en_o && osc_ext_en_o && !reg_lowpwr_o));
  a_r8_deep_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == PS_DEEP) |-> (!core_clk_en_o && !cpu_clk_en_o && !osc_int_en_o && !osc_ext_en_o));
  a_r9_oscw_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == PS_OSCW) |-> (osc_int_en_o && osc_ext_en_o && !core_clk_en_o && !reg_lowpwr_o));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int N_IRQ = 4,
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_deep_i,
  input  logic             cfg_on_exit_i,
  input  logic             cfg_lp_sel_i,
  input  logic             cfg_reg_lp_i,
  input  logic             cfg_sev_pend_i,
  input  logic [N_EVT-1:0] cfg_evt_mode_i,
  input  logic             wfi_i,
  input  logic             wfe_i,
  input  logic             handler_exit_i,
  input  logic [N_IRQ-1:0] irq_pend_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_EVT-1:0] evt_line_i,
  input  logic             osc_ready_i,
  output logic [1:0]       lp_state_o,
  output logic             cpu_clk_en_o,
  output logic             core_clk_en_o,
  output logic             osc_int_en_o,
  output logic             osc_ext_en_o,
  output logic             reg_lowpwr_o,
  output logic             wake_fast_o,
  output logic             wake_irq_o
);
  pwr_state_e state;
  logic irq_src, evt_src, latched, consume, reg_lp_q;

  pwr_wake_detect #(.N_IRQ(N_IRQ), .N_EVT(N_EVT)) u_wake (
    .sev_pend_i (cfg_sev_pend_i),
    .irq_pend_i (irq_pend_i),
    .irq_en_i   (irq_en_i),
    .evt_line_i (evt_line_i),
    .evt_mode_i (cfg_evt_mode_i),
    .irq_src_o  (irq_src),
    .evt_src_o  (evt_src)
  );

  pwr_event_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_run_i  (state == PS_RUN),
    .evt_src_i (evt_src),
    .consume_i (consume),
    .latched_o (latched)
  );

  pwr_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_deep_i     (cfg_deep_i),
    .cfg_on_exit_i  (cfg_on_exit_i),
    .cfg_lp_sel_i   (cfg_lp_sel_i),
    .cfg_reg_lp_i   (cfg_reg_lp_i),
    .wfi_i          (wfi_i),
    .wfe_i          (wfe_i),
    .handler_exit_i (handler_exit_i),
    .irq_src_i      (irq_src),
    .evt_src_i      (evt_src),
    .latched_i      (latched),
    .osc_ready_i    (osc_ready_i),
    .state_o        (state),
    .reg_lp_q_o     (reg_lp_q),
    .consume_o      (consume),
    .wake_fast_o    (wake_fast_o),
    .wake_irq_o     (wake_irq_o)
  );

  pwr_clk_ctrl u_clk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_i       (state),
    .reg_lp_q_i    (reg_lp_q),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .core_clk_en_o (core_clk_en_o),
    .osc_int_en_o  (osc_int_en_o),
    .osc_ext_en_o  (osc_ext_en_o),
    .reg_lowpwr_o  (reg_lowpwr_o)
  );

  assign lp_state_o = state;

  a_r10_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PS_RUN) |=> (lp_state_o != 2'd0 || wake_fast_o || wake_irq_o));
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_deep = 0, cfg_on_exit = 0, cfg_lp_sel = 0, cfg_reg_lp = 0, cfg_sev = 0;
  logic [3:0] cfg_evt_mode = 4'b0011;
  logic wfi = 0, wfe = 0, hexit = 0, osc_rdy = 0;
  logic [3:0] irq_pend = 0, irq_en = 4'b0001, evt_line = 0;
  logic [1:0] lp_state;
  logic cpu_en, core_en, osci_en, osce_en, reg_lp, wk_fast, wk_irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pwr_mode_seq #(.N_IRQ(4), .N_EVT(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_deep_i(cfg_deep), .cfg_on_exit_i(cfg_on_exit), .cfg_lp_sel_i(cfg_lp_sel),
    .cfg_reg_lp_i(cfg_reg_lp), .cfg_sev_pend_i(cfg_sev), .cfg_evt_mode_i(cfg_evt_mode),
    .wfi_i(wfi), .wfe_i(wfe), .handler_exit_i(hexit),
    .irq_pend_i(irq_pend), .irq_en_i(irq_en), .evt_line_i(evt_line), .osc_ready_i(osc_rdy),
    .lp_state_o(lp_state), .cpu_clk_en_o(cpu_en), .core_clk_en_o(core_en),
    .osc_int_en_o(osci_en), .osc_ext_en_o(osce_en), .reg_lowpwr_o(reg_lp),
    .wake_fast_o(wk_fast), .wake_irq_o(wk_irq)
  );

  // expected port vector {state, cpu, core, osc_int, osc_ext, reg_lp, fast, irq}
  logic [8:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [8:0] model(input logic [1:0] st, input logic rl, input logic f, input logic i);
    return {st, st == 2'd0, st <= 2'd1, st != 2'd2, st != 2'd2, rl, f, i};
  endfunction

  task automatic compare(input logic [8:0] exp, input string tag);
    logic [8:0] got;
    got = {lp_state, cpu_en, core_en, osci_en, osce_en, reg_lp, wk_fast, wk_irq};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push what the ports must show after the edge
  task automatic step(input logic w_i, input logic w_e, input logic hx,
                      input logic [3:0] pend, input logic [3:0] ev, input logic ordy,
                      input logic [1:0] st, input logic rl, input logic f, input logic i,
                      input string tag);
    @(negedge clk);
    wfi = w_i; wfe = w_e; hexit = hx;
    irq_pend = pend; evt_line = ev; osc_rdy = ordy;
    exp_q.push_back(model(st, rl, f, i));
    tag_q.push_back(tag);
  endtask

  // quiet cycle used to change configuration bits
  task automatic quiet();
    @(negedge clk);
    wfi = 0; wfe = 0; hexit = 0; irq_pend = 0; evt_line = 0; osc_rdy = 0;
  endtask

  // monitor: pops one expectation after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compare(e, t);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(model(2'd0, 1'b0, 1'b0, 1'b0), "R1 reset state");

    // light sleep, interrupt entry
    step(1,0,0,4'b0000,4'b0000,0, 2'd1,0,0,0, "R2 wfi enters sleep");
    step(0,0,0,4'b0010,4'b0000,0, 2'd1,0,0,0, "R5 unenabled pending no wake; R4 gates");
    step(1,0,0,4'b0010,4'b0000,0, 2'd1,0,0,0, "R10 wfi in sleep ignored");
    step(0,0,0,4'b0001,4'b0000,0, 2'd0,0,0,1, "R5 enabled irq wakes");
    step(0,0,0,4'b0000,4'b0000,0, 2'd0,0,0,0, "R5 pulse one cycle");
    // light sleep, event entry
    step(0,1,0,4'b0000,4'b0000,0, 2'd1,0,0,0, "R2 wfe enters sleep");
    step(0,0,0,4'b0000,4'b0100,0, 2'd1,0,0,0, "R6 line without mode no wake");
    step(0,0,0,4'b0010,4'b0000,0, 2'd1,0,0,0, "R6 pending w/o send-on-pending no wake");
    step(0,0,0,4'b0000,4'b0001,0, 2'd0,0,1,0, "R6 event line wakes");
    step(0,0,0,4'b0000,4'b0000,0, 2'd0,0,0,0, "R6 pulse one cycle");
    quiet(); cfg_sev = 1;
    step(0,1,0,4'b0000,4'b0000,0, 2'd1,0,0,0, "R2 wfe enters sleep again");
    step(0,0,0,4'b0010,4'b0000,0, 2'd0,0,1,0, "R6 pending unenabled with send-on-pending wakes");
    step(0,0,0,4'b0000,4'b0000,0, 2'd0,0,0,0, "R6 back in run");
    // event latch
    step(0,0,0,4'b0000,4'b0010,0, 2'd0,0,0,0, "R11 event in run");
    step(0,0,0,4'b0000,4'b0000,0, 2'd0,0,0,0, "R11 idle");
    step(0,1,0,4'b0000,4'b0000,0, 2'd0,0,1,0, "R11 latched wfe stays in run");
    step(0,1,0,4'b0000,4'b0000,0, 2'd1,0,0,0, "R11 latch consumed, wfe sleeps");
    step(0,0,0,4'b0000,4'b0001,0, 2'd0,0,1,0, "R11 wake after consumed latch");
    step(0,0,0,4'b0000,4'b0001,0, 2'd0,0,0,0, "R11 event latched again");
    step(1,0,0,4'b0000,4'b0000,0, 2'd1,0,0,0, "R11 wfi sleeps despite latch");
    step(0,0,0,4'b0001,4'b0000,0, 2'd0,0,0,1, "R11 irq wake from wfi");
    step(0,1,0,4'b0000,4'b0000,0, 2'd0,0,1,0, "R11 wfi kept latch");
    // sleep on handler exit
    quiet(); cfg_on_exit = 1;
    step(1,0,0,4'b0000,4'b0000,0, 2'd0,0,0,0, "R3 wfi ignored with on-exit");
    step(0,1,0,4'b0000,4'b0000,0, 2'd0,0,0,0, "R3 wfe ignored with on-exit");
    step(0,0,1,4'b0000,4'b0000,0, 2'd1,0,0,0, "R3 handler exit enters sleep");
    step(0,0,0,4'b0001,4'b0000,0, 2'd0,0,0,1, "R3 wakes by irq rules");
    quiet(); cfg_on_exit = 0;
    step(0,0,1,4'b0000,4'b0000,0, 2'd0,0,0,0, "R3 handler exit ignored");
    // deep sleep
    quiet(); cfg_deep = 1; cfg_lp_sel = 1;
    step(1,0,0,4'b0000,4'b0000,0, 2'd0,0,0,0, "R7 lowest-power select ignores strobe");
    quiet(); cfg_lp_sel = 0; cfg_reg_lp = 1;
    step(1,0,0,4'b0000,4'b0000,0, 2'd2,1,0,0, "R7 wfi enters deep; R8 regulator low");
    quiet(); cfg_reg_lp = 0;
    step(0,0,0,4'b0000,4'b0000,0, 2'd2,1,0,0, "R8 regulator held from entry");
    step(0,1,0,4'b0000,4'b0000,0, 2'd2,1,0,0, "R10 wfe in deep ignored");
    step(0,0,0,4'b0001,4'b0000,0, 2'd3,0,0,0, "R9 wake goes to oscillator wait");
    step(0,0,0,4'b0000,4'b0000,0, 2'd3,0,0,0, "R9 waits for ready");
    step(0,0,0,4'b0000,4'b0000,1, 2'd0,0,0,1, "R9 ready returns to run with irq pulse");
    step(0,0,0,4'b0000,4'b0000,0, 2'd0,0,0,0, "R9 run");
    step(0,1,0,4'b0000,4'b0000,0, 2'd2,0,0,0, "R8 deep by wfe regulator normal");
    step(0,0,0,4'b0000,4'b0001,0, 2'd3,0,0,0, "R9 event wake to oscillator wait");
    step(0,0,0,4'b0000,4'b0000,1, 2'd0,0,1,0, "R9 ready returns with fast pulse");
    quiet();
    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule